// File: doc/BRIEF.md
# Eight-Channel Thermal and Supply Protection Supervisor

This block sits between the logic that commands a bank of high-side output channels and the power stage that drives them. For every channel it receives a junction temperature code from an external converter, and it receives one code for the shared driver supply. It forwards a channel's commanded enable to the power stage only while that channel is cool enough and the supply is healthy. It also raises one shared fault flag for the whole bank.

Each channel has its own thermal latch. The latch opens when the channel reaches the trip temperature. It closes only after the channel has cooled below the trip point minus a hysteresis band. While the latch is open, the channel restarts by itself once it has cooled, as long as it is still commanded on. A hot channel never affects its neighbours. A supply lockout with separate shutdown and restart thresholds gates every channel at once. The active-low diagnostic flag goes low while any channel is thermally latched or the supply is locked out.

Both converter inputs work as streams that are only ever valid. Each code is taken on a clock edge where its valid strobe is high. The block accepts every sample in the cycle it arrives, so it never applies back-pressure and has no ready output. A producer may hold valid high all the time, or pulse it at its own conversion rate. Codes presented without valid are ignored.

Top module: `chan_protect_supervisor`

## Requirements
- R1: After reset, `en_out` is all zeros and `diag_n` is 0. Both stay there until a supply sample above the restart threshold has been accepted, whatever the commands and temperatures are.
- R2: A temperature sample whose code is at or above `TRIP_DEGC + TEMP_OFFSET` (135 °C with the defaults; code = °C + 50) latches that channel off. The channel's `en_out` bit is 0 from the second clock edge after the sample's edge onward.
- R3: A latched channel stays off for samples from the clear code (trip code minus `HYST_K`, 125 °C by default) up to the trip code. A sample strictly below the clear code releases it, and the channel restarts without a new command if its enable is still high.
- R4: The thermal latch of one channel has no effect on the `en_out` bit of any other channel.
- R5: A supply sample at or below `UV_OFF_DV` (code in 0.1 V steps, 70 = 7.0 V) forces every `en_out` bit to 0.
- R6: While the supply is locked out, samples from `UV_OFF_DV`+1 up to and including `UV_ON_DV` (105 = 10.5 V) keep it locked out. A sample above `UV_ON_DV` releases it. While the supply is not locked out, samples above `UV_OFF_DV` keep it released.
- R7: Bit c of `en_out` equals, one clock later, `cmd_en[c]` AND NOT the channel's thermal latch AND NOT the supply lockout.
- R8: `diag_n` is 0 one clock after any thermal latch or the supply lockout is set, and 1 one clock after all of them are clear.
- R9: Temperature or supply codes presented while their valid strobe is low change no state and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_en | input | N_CH | Commanded enable per channel |
| temp_vld | input | 1 | Temperature codes valid this cycle |
| temp_code | input | N_CH*8 | Packed temperature codes, channel c at bits [8c+7:8c], °C + TEMP_OFFSET |
| vsup_vld | input | 1 | Supply code valid this cycle |
| vsup_code | input | 8 | Driver supply level in 0.1 V steps |
| en_out | output | N_CH | Gated enables to the power stage |
| diag_n | output | 1 | Common diagnostic, low on any fault |

## Verification
The hardest states to reach are the hysteresis bands. A thermal latch or the supply lockout must be observed holding while the input sits inside its band. The stimulus first drives a channel over the trip code. It then walks the temperature down through codes inside the band and lands exactly on the clear code, and only then goes one below it. The supply gets the same treatment, approaching the lockout from the healthy side and the restart threshold from the locked side. Ignored samples are shown by parking a trip-level code on an input with its strobe low and watching the outputs stay put.

// File: rtl/chan_protect_pkg.sv
package chan_protect_pkg;
  parameter int unsigned CODE_W = 8;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/thermal_latch.sv
module thermal_latch
  import chan_protect_pkg::*;
#(
  parameter int unsigned TRIP_CODE  = 185,
  parameter int unsigned CLEAR_CODE = 175
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sample_vld,
  input  code_t code,
  output logic  hot
);
  localparam code_t TRIP_C  = code_t'(TRIP_CODE);
  localparam code_t CLEAR_C = code_t'(CLEAR_CODE);

  // Set at or above trip, clear strictly below trip minus hysteresis.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hot <= 1'b0;
    end else if (sample_vld) begin
      if (code >= TRIP_C)      hot <= 1'b1;
      else if (code < CLEAR_C) hot <= 1'b0;
    end
  end
endmodule

// File: rtl/supply_lockout.sv
module supply_lockout
  import chan_protect_pkg::*;
#(
  parameter int unsigned OFF_CODE = 70,
  parameter int unsigned ON_CODE  = 105
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sample_vld,
  input  code_t code,
  output logic  locked
);
  localparam code_t OFF_C = code_t'(OFF_CODE);
  localparam code_t ON_C  = code_t'(ON_CODE);

  // Starts locked; only a sample above the restart level releases it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b1;
    end else if (sample_vld) begin
      if (code <= OFF_C)    locked <= 1'b1;
      else if (code > ON_C) locked <= 1'b0;
    end
  end
endmodule

// File: rtl/prot_out_stage.sv
module prot_out_stage #(
  parameter int unsigned N_CH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] cmd_en,
  input  logic [N_CH-1:0] hot,
  input  logic            uv_lock,
  output logic [N_CH-1:0] en_out,
  output logic            diag_n
);
  logic [N_CH-1:0] gate_d;
  logic            fault_d;

  always_comb begin
    gate_d  = cmd_en & ~hot & ~{N_CH{uv_lock}};
    fault_d = (|hot) | uv_lock;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_out <= '0;
      diag_n <= 1'b0;
    end else begin
      en_out <= gate_d;
      diag_n <= ~fault_d;
    end
  end
endmodule

// File: rtl/chan_protect_supervisor.sv
module chan_protect_supervisor
  import chan_protect_pkg::*;
#(
  parameter int unsigned N_CH        = 8,
  parameter int unsigned TEMP_OFFSET = 50,
  parameter int unsigned TRIP_DEGC   = 135,
  parameter int unsigned HYST_K      = 10,
  parameter int unsigned UV_OFF_DV   = 70,
  parameter int unsigned UV_ON_DV    = 105
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_CH-1:0]        cmd_en,
  input  logic                   temp_vld,
  input  logic [N_CH*CODE_W-1:0] temp_code,
  input  logic                   vsup_vld,
  input  logic [CODE_W-1:0]      vsup_code,
  output logic [N_CH-1:0]        en_out,
  output logic                   diag_n
);
  localparam int unsigned TRIP_CODE  = TRIP_DEGC + TEMP_OFFSET;
  localparam int unsigned CLEAR_CODE = TRIP_CODE - HYST_K;

  logic [N_CH-1:0] hot_vec;
  logic            uv_lock;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    thermal_latch #(
      .TRIP_CODE (TRIP_CODE),
      .CLEAR_CODE(CLEAR_CODE)
    ) u_therm (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample_vld(temp_vld),
      .code      (temp_code[c*CODE_W +: CODE_W]),
      .hot       (hot_vec[c])
    );
  end

  supply_lockout #(
    .OFF_CODE(UV_OFF_DV),
    .ON_CODE (UV_ON_DV)
  ) u_uvlo (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_vld(vsup_vld),
    .code      (vsup_code),
    .locked    (uv_lock)
  );

  prot_out_stage #(
    .N_CH(N_CH)
  ) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_en (cmd_en),
    .hot    (hot_vec),
    .uv_lock(uv_lock),
    .en_out (en_out),
    .diag_n (diag_n)
  );
endmodule

// File: rtl/chan_protect_sva.sv
module chan_protect_sva
  import chan_protect_pkg::*;
#(
  parameter int unsigned N_CH       = 8,
  parameter int unsigned TRIP_CODE  = 185,
  parameter int unsigned CLEAR_CODE = 175,
  parameter int unsigned UV_OFF     = 70,
  parameter int unsigned UV_ON      = 105
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [N_CH-1:0]        cmd_en,
  input logic                   temp_vld,
  input logic [N_CH*CODE_W-1:0] temp_code,
  input logic                   vsup_vld,
  input logic [CODE_W-1:0]      vsup_code,
  input logic [N_CH-1:0]        hot,
  input logic                   uv_lock,
  input logic [N_CH-1:0]        en_out,
  input logic                   diag_n
);
  localparam code_t TRIP_C  = code_t'(TRIP_CODE);
  localparam code_t CLEAR_C = code_t'(CLEAR_CODE);
  localparam code_t OFF_C   = code_t'(UV_OFF);
  localparam code_t ON_C    = code_t'(UV_ON);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R7: registered gating from command and fault state
  a_r7_gated_enable: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    en_out == ($past(cmd_en) & ~$past(hot) & ~{N_CH{$past(uv_lock)}}));

  // R8: diagnostic tracks OR of faults one clock later
  a_r8_diag_merge: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    diag_n == !($past(|hot) || $past(uv_lock)));

  // R5: low supply sample locks out
  a_r5_uv_shut: assert property (@(posedge clk) disable iff (!rst_n)
    (vsup_vld && vsup_code <= OFF_C) |=> uv_lock);

  // R6: high supply sample releases
  a_r6_uv_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (vsup_vld && vsup_code > ON_C) |=> !uv_lock);

  // R9: no supply sample, no lockout change
  a_r9_uv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vsup_vld |=> $stable(uv_lock));

  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    // R2: trip-level sample latches the channel
    a_r2_trip: assert property (@(posedge clk) disable iff (!rst_n)
      (temp_vld && temp_code[c*CODE_W +: CODE_W] >= TRIP_C) |=> hot[c]);
    // R3: below clear code releases; inside band holds
    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (temp_vld && temp_code[c*CODE_W +: CODE_W] < CLEAR_C) |=> !hot[c]);
    a_r3_band_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (temp_vld && temp_code[c*CODE_W +: CODE_W] >= CLEAR_C
                && temp_code[c*CODE_W +: CODE_W] < TRIP_C) |=> $stable(hot[c]));
    // R9: no temperature sample, no latch change
    a_r9_temp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !temp_vld |=> $stable(hot[c]));
  end
endmodule

bind chan_protect_supervisor chan_protect_sva #(
  .N_CH      (N_CH),
  .TRIP_CODE (TRIP_CODE),
  .CLEAR_CODE(CLEAR_CODE),
  .UV_OFF    (UV_OFF_DV),
  .UV_ON     (UV_ON_DV)
) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_en   (cmd_en),
  .temp_vld (temp_vld),
  .temp_code(temp_code),
  .vsup_vld (vsup_vld),
  .vsup_code(vsup_code),
  .hot      (hot_vec),
  .uv_lock  (uv_lock),
  .en_out   (en_out),
  .diag_n   (diag_n)
);

// File: tb/test_chan_protect_supervisor.sv
module test_chan_protect_supervisor;
  localparam int NCH = 8;
  localparam int OFS = 50;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] cmd_en = '0;
  logic           temp_vld = 1'b0;
  logic [NCH*8-1:0] temp_code = '0;
  logic           vsup_vld = 1'b0;
  logic [7:0]     vsup_code = '0;
  logic [NCH-1:0] en_out;
  logic           diag_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  chan_protect_supervisor i_chan_protect_supervisor (
    .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .temp_vld(temp_vld),
    .temp_code(temp_code), .vsup_vld(vsup_vld), .vsup_code(vsup_code),
    .en_out(en_out), .diag_n(diag_n)
  );

  always #10ns clk = ~clk;

  // Behavioural reference in degrees and volts
  bit m_hot [NCH];
  bit m_uv;
  logic [NCH-1:0] m_en;
  bit m_diag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_hot[i]) m_hot[i] = 0;
      m_uv = 1; m_en = '0; m_diag = 0;
    end else begin
      bit any;
      any = m_uv;
      for (int i = 0; i < NCH; i++) begin
        m_en[i] = cmd_en[i] && !m_hot[i] && !m_uv;
        if (m_hot[i]) any = 1;
      end
      m_diag = !any;
      if (temp_vld)
        for (int i = 0; i < NCH; i++) begin
          int degc;
          degc = int'(temp_code[i*8 +: 8]) - OFS;
          if (degc >= 135) m_hot[i] = 1;
          else if (degc < 125) m_hot[i] = 0;
        end
      if (vsup_vld) begin
        if (vsup_code <= 70) m_uv = 1;
        else if (vsup_code > 105) m_uv = 0;
      end
    end
  end

  // R7/R8 continuous comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (en_out !== m_en) begin
        fails++;
        $display("FAIL R7 model en_out actual=%h expected=%h", en_out, m_en);
      end
      checks++;
      if (diag_n !== m_diag) begin
        fails++;
        $display("FAIL R8 model diag_n actual=%b expected=%b", diag_n, m_diag);
      end
    end
  end

  task automatic expect_out(string tag, logic [NCH-1:0] e_en, logic e_diag);
    checks++;
    if (en_out !== e_en || diag_n !== e_diag) begin
      fails++;
      $display("FAIL %s en_out/diag_n actual=%h/%b expected=%h/%b",
               tag, en_out, diag_n, e_en, e_diag);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_temp(int ch, int degc);
    temp_code[ch*8 +: 8] = 8'(degc + OFS);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) set_temp(i, 25);
    cmd_en = 8'hFF; temp_vld = 1; vsup_code = 8'd120; vsup_vld = 0;
    step(3);
    expect_out("R1 in reset", 8'h00, 1'b0);
    rst_n = 1;
    step(4);
    expect_out("R1 no supply sample yet", 8'h00, 1'b0);
    expect_out("R9 unstrobed supply ignored", 8'h00, 1'b0);
    vsup_vld = 1; step(2);
    expect_out("R6 supply release", 8'hFF, 1'b1);

    set_temp(3, 135); step(2);
    expect_out("R2 trip at 135", 8'hF7, 1'b0);
    expect_out("R4 neighbours stay on", 8'hF7, 1'b0);
    set_temp(3, 130); step(2);
    expect_out("R3 inside band holds", 8'hF7, 1'b0);
    set_temp(3, 125); step(2);
    expect_out("R3 at clear code holds", 8'hF7, 1'b0);
    set_temp(3, 124); step(2);
    expect_out("R3 release and restart", 8'hFF, 1'b1);

    set_temp(5, 150); set_temp(1, 140); step(2);
    expect_out("R4 two hot channels", 8'hDD, 1'b0);
    cmd_en = 8'h0F; step(2);
    expect_out("R7 command masks", 8'h0D, 1'b0);
    set_temp(5, 20); set_temp(1, 20); step(2);
    expect_out("R8 diag clears", 8'h0F, 1'b1);
    cmd_en = 8'hFF; step(2);

    temp_vld = 0; set_temp(0, 200); step(3);
    expect_out("R9 unstrobed temp ignored", 8'hFF, 1'b1);
    temp_vld = 1; step(2);
    expect_out("R2 strobed trip", 8'hFE, 1'b0);
    set_temp(0, 30); step(2);

    vsup_code = 8'd80; step(2);
    expect_out("R6 released stays above off", 8'hFF, 1'b1);
    vsup_code = 8'd70; step(2);
    expect_out("R5 lockout at 7.0V", 8'h00, 1'b0);
    vsup_code = 8'd100; step(2);
    expect_out("R6 band holds", 8'h00, 1'b0);
    vsup_code = 8'd105; step(2);
    expect_out("R6 at restart level holds", 8'h00, 1'b0);
    vsup_code = 8'd106; step(2);
    expect_out("R6 restart above 10.5V", 8'hFF, 1'b1);

    set_temp(6, 160); vsup_code = 8'd50; step(2);
    expect_out("R5 lockout with hot channel", 8'h00, 1'b0);
    vsup_code = 8'd120; step(2);
    expect_out("R4 only hot channel off", 8'hBF, 1'b0);
    set_temp(6, 25); step(2);

    rst_n = 0; step(1);
    expect_out("R1 mid-run reset", 8'h00, 1'b0);
    rst_n = 1; vsup_vld = 0; step(3);
    expect_out("R1 waits for supply", 8'h00, 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20ns * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule